// File: doc/BRIEF.md
# Four-Wire Serial Command Port (Slave)

This block is the slave side of a full-duplex, byte-oriented serial control port. A host drives four wires: a serial clock, an active-low select, a data line into the block and a data line out of it. While the select is low, the block shifts one command byte in, most significant bit first. At the same time it shifts out a byte that the core supplied. When the select is released, the received byte is handed to the core as a one-cycle strobe with parallel data. The serial clock, the select and the input data are oversampled by a system clock that runs at least eight times faster than the serial clock.

Frames need not hold exactly eight clocks. A short frame arrives right-aligned, with zeros above the received bits. A long frame keeps only the last eight bits received. A frame with no clock at all produces no strobe. The first output bit is presented when the select falls. Each later bit moves on a falling serial-clock edge. After the eighth bit of the transmit byte, the output line echoes the bits received on the input, in the order they arrived. A separate enable drives an external tri-state pad, so the output is high-impedance whenever the select is high.

Top module: `hsp_top`

## Requirements
- R1: After synchronous reset, `rx_valid_o` is 0, `rx_byte_o` is 0 and `miso_oe_o` is 0.
- R2: A frame of exactly 8 serial-clock rising edges yields `rx_byte_o` equal to the 8 sampled input bits (first bit in bit 7). `rx_valid_o` is high for exactly one cycle, three system clocks after the select rises.
- R3: A frame of N rising edges with 1 ≤ N < 8 yields the N bits in `rx_byte_o[N-1:0]`, with the first one in bit N-1 and zeros above.
- R4: A frame of more than 8 rising edges yields the last 8 bits received, the latest one in bit 0.
- R5: A frame with no rising edge produces no `rx_valid_o` pulse and leaves `rx_byte_o` unchanged.
- R6: Three system clocks after the select falls, `miso_oe_o` is 1 and `miso_o` shows bit 7 of `tx_byte_i` as sampled at that moment.
- R7: `miso_o` advances by one bit on each falling serial-clock edge that follows a rising edge in the same frame. After the k-th such edge (k < 8) it shows bit 7-k of the loaded transmit byte.
- R8: From the 8th falling edge on, `miso_o` echoes the input bits in arrival order: after falling edge k ≥ 8 it shows input bit k-8, counting from 0.
- R9: Three system clocks after the select rises, `miso_oe_o` is 0, and it stays 0 while the select stays high.
- R10: Serial-clock and input-data activity while the select is high has no effect: no strobe, and `rx_byte_o` and `miso_oe_o` stay unchanged.
- R11: A falling serial-clock edge that comes before the first rising edge of a frame does not advance `miso_o` (idle-high clock).
- R12: Changes on `tx_byte_i` after the select falls do not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host |
| ssn_i | input | 1 | Active-low frame select from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the external tri-state pad |
| tx_byte_i | input | BYTE_W | Byte to send, loaded when the select falls |
| rx_valid_o | output | 1 | One-cycle strobe: a received byte is ready |
| rx_byte_o | output | BYTE_W | Received byte, held until the next strobe |

## Verification
Every output reacts three system clocks after the pin change that causes it: two synchronizer flops, then the register that acts on the detected edge. The strobe is polled on each of six cycles after the select rises, and it must appear on the third poll and on no other. Output-bit and enable checks wait four cycles after the causing edge, which is one cycle of margin past the three-cycle latency. The next stimulus edge comes only after that check. The received byte is compared only on the strobe cycle.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    // Bit positions of the host lines inside the synchronizer vector
    localparam int IDX_MOSI = 0;
    localparam int IDX_SSN  = 1;
    localparam int IDX_SCK  = 2;
    localparam int LINE_W   = 3;

    // Events seen in the system-clock domain, one cycle wide
    typedef struct packed {
        logic active;    // select is low
        logic start;     // select just fell
        logic stop;      // select just rose
        logic sck_rise;  // sampling edge inside a frame
        logic sck_fall;  // shifting edge inside a frame
        logic mosi;      // input bit aligned with sck_rise
    } link_ev_t;

    // Idle level of the lines: select high, clock and data low
    function automatic logic [LINE_W-1:0] idle_lines();
        logic [LINE_W-1:0] v;
        v = '0;
        v[IDX_SSN] = 1'b1;
        return v;
    endfunction

    function automatic link_ev_t decode_lines(input logic [LINE_W-1:0] cur,
                                              input logic [LINE_W-1:0] prev);
        link_ev_t e;
        e.active   = ~cur[IDX_SSN];
        e.start    = ~cur[IDX_SSN] &  prev[IDX_SSN];
        e.stop     =  cur[IDX_SSN] & ~prev[IDX_SSN];
        e.sck_rise = e.active & ~e.start &  cur[IDX_SCK] & ~prev[IDX_SCK];
        e.sck_fall = e.active & ~e.start & ~cur[IDX_SCK] &  prev[IDX_SCK];
        e.mosi     = cur[IDX_MOSI];
        return e;
    endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int WIDTH     = 3,
    parameter int STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign cur_o  = chain[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/hsp_rx_shift.sv
module hsp_rx_shift
    import hsp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  link_ev_t          ev,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              last_bit_o,
    output logic              rise_seen_o
);
    localparam int CNT_W   = $clog2(2 * BYTE_W);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            rx_valid_o <= 1'b0;
            rx_byte_o  <= '0;
        end else begin
            rx_valid_o <= 1'b0;
            if (ev.start) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else if (ev.sck_rise) begin
                sh_q <= {sh_q[BYTE_W-2:0], ev.mosi};
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
            if (ev.stop && cnt_q != '0) begin
                rx_valid_o <= 1'b1;
                rx_byte_o  <= sh_q;
            end
        end
    end

    assign last_bit_o  = sh_q[0];
    assign rise_seen_o = (cnt_q != '0);
endmodule

// File: rtl/hsp_tx_shift.sv
module hsp_tx_shift
    import hsp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  link_ev_t          ev,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              echo_bit_i,
    input  logic              rise_seen_i,
    output logic              miso_o,
    output logic              miso_oe_o
);
    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            miso_oe_o <= 1'b0;
        end else begin
            miso_oe_o <= ev.active;
            if (ev.start) begin
                sh_q <= tx_byte_i;
            end else if (ev.sck_fall && rise_seen_i) begin
                // refill from the receive side so the output echoes the input
                sh_q <= {sh_q[BYTE_W-2:0], echo_bit_i};
            end
        end
    end

    assign miso_o = sh_q[BYTE_W-1];
endmodule

// File: rtl/hsp_top.sv
module hsp_top
    import hsp_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              ssn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic [LINE_W-1:0] lines_raw;
    logic [LINE_W-1:0] lines_cur;
    logic [LINE_W-1:0] lines_prev;
    link_ev_t          ev;
    logic              echo_bit;
    logic              rise_seen;

    always_comb begin
        lines_raw           = '0;
        lines_raw[IDX_MOSI] = mosi_i;
        lines_raw[IDX_SSN]  = ssn_i;
        lines_raw[IDX_SCK]  = sck_i;
    end

    hsp_sync #(
        .WIDTH   (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (idle_lines())
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (lines_raw),
        .cur_o  (lines_cur),
        .prev_o (lines_prev)
    );

    assign ev = decode_lines(lines_cur, lines_prev);

    hsp_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .rx_valid_o  (rx_valid_o),
        .rx_byte_o   (rx_byte_o),
        .last_bit_o  (echo_bit),
        .rise_seen_o (rise_seen)
    );

    hsp_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .tx_byte_i   (tx_byte_i),
        .echo_bit_i  (echo_bit),
        .rise_seen_i (rise_seen),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o)
    );
endmodule

// File: rtl/hsp_checker.sv
module hsp_checker (
    input logic clk,
    input logic rst,
    input logic ssn_i,
    input logic miso_oe_o,
    input logic rx_valid_o
);
    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ssn_i && $past(ssn_i) && $past(ssn_i, 2) && $past(ssn_i, 3)) |-> !miso_oe_o); // R9

    AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
        (!ssn_i && !$past(ssn_i) && !$past(ssn_i, 2) && !$past(ssn_i, 3)
         && !$past(rst) && !$past(rst, 2) && !$past(rst, 3)) |-> miso_oe_o); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R2

    AST_VALID_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> !miso_oe_o); // R2
endmodule

bind hsp_top hsp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ssn_i      (ssn_i),
    .miso_oe_o  (miso_oe_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/hsp_top_bench.sv
module hsp_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck_i = 1'b0;
    logic       ssn_i = 1'b1;
    logic       mosi_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic       miso_o;
    logic       miso_oe_o;
    logic       rx_valid_o;
    logic [7:0] rx_byte_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    hsp_top u_hsp_top (
        .clk        (clk),
        .rst        (rst),
        .sck_i      (sck_i),
        .ssn_i      (ssn_i),
        .mosi_i     (mosi_i),
        .miso_o     (miso_o),
        .miso_oe_o  (miso_oe_o),
        .tx_byte_i  (tx_byte_i),
        .rx_valid_o (rx_valid_o),
        .rx_byte_o  (rx_byte_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] tx, input logic [31:0] pat,
                             input int n, input bit idle_hi);
        logic [7:0] prev_rx;
        logic [7:0] exp_rx;
        logic       exp_bit;
        int         pulses;
        int         first_at;
        string      tag;
        sck_i = idle_hi;
        wait_n(4);
        tx_byte_i = tx;
        prev_rx   = rx_byte_o;
        ssn_i     = 1'b0;
        wait_n(4);
        chk(miso_oe_o == 1'b1, "R6 enable", miso_oe_o, 1);
        chk(miso_o == tx[7], "R6 first bit", miso_o, tx[7]);
        tx_byte_i = ~tx;  // R12: must not reach the shifter
        if (idle_hi) begin
            sck_i = 1'b0;
            wait_n(4);
            chk(miso_o == tx[7], "R11 early fall", miso_o, tx[7]);
        end
        for (int i = 0; i < n; i++) begin
            mosi_i = pat[n-1-i];
            wait_n(4);
            sck_i = 1'b1;
            wait_n(4);
            sck_i = 1'b0;
            wait_n(4);
            if (i + 1 < 8) begin
                exp_bit = tx[6-i];
                chk(miso_o == exp_bit, "R7/R12 shift", miso_o, exp_bit);
            end else begin
                exp_bit = pat[n+7-(i+1)];
                chk(miso_o == exp_bit, "R8 echo", miso_o, exp_bit);
            end
        end
        ssn_i    = 1'b1;
        pulses   = 0;
        first_at = 0;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (rx_valid_o) begin
                pulses++;
                if (first_at == 0) first_at = c;
                if (n >= 8) exp_rx = pat[7:0];
                else        exp_rx = pat[7:0] & ((8'd1 << n) - 8'd1);
                tag = (n == 8) ? "R2 byte" : (n < 8) ? "R3 short byte" : "R4 long byte";
                chk(rx_byte_o == exp_rx, tag, rx_byte_o, exp_rx);
            end
        end
        if (n == 0) begin
            chk(pulses == 0, "R5 no strobe", pulses, 0);
            chk(rx_byte_o == prev_rx, "R5 byte kept", rx_byte_o, prev_rx);
        end else begin
            chk(pulses == 1, "R2 single strobe", pulses, 1);
            chk(first_at == 3, "R2 strobe latency", first_at, 3);
        end
        chk(miso_oe_o == 1'b0, "R9 release", miso_oe_o, 0);
    endtask

    initial begin
        for (;;) begin
            @(posedge clk);
            cyc++;
            if (cyc >= 200000) begin
                n_chk++;
                n_err++;
                $display("FAIL watchdog actual=%0d expected=<200000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] held;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        chk(rx_valid_o == 1'b0, "R1 strobe", rx_valid_o, 0);
        chk(rx_byte_o == 8'h00, "R1 byte", rx_byte_o, 0);
        chk(miso_oe_o == 1'b0, "R1 enable", miso_oe_o, 0);

        // R2 R6 R7 R8 R11 R12: every byte value, both clock idle levels
        for (int v = 0; v < 256; v++)
            run_frame(8'((v * 37 + 11) & 255), 32'(v), 8, v[0]);

        // R3: every pattern of every short length
        for (int n = 1; n < 8; n++)
            for (int p = 0; p < (1 << n); p++)
                run_frame(8'(p * 5 + n), 32'(p), n, p[1]);

        // R4: long frames
        for (int n = 9; n <= 16; n++)
            for (int k = 0; k < 4; k++)
                run_frame(8'(n * 19 + k), 32'(((n * 40503 + k * 7919) & ((1 << n) - 1))), n, k[0]);

        // R5: empty frames, both idle levels
        run_frame(8'hA5, 32'h0, 0, 1'b0);
        run_frame(8'h3C, 32'h0, 0, 1'b1);

        // R10: activity with select high
        held = rx_byte_o;
        for (int i = 0; i < 20; i++) begin
            mosi_i = i[0];
            sck_i  = ~sck_i;
            wait_n(2);
            chk(rx_valid_o == 1'b0, "R10 no strobe", rx_valid_o, 0);
            chk(miso_oe_o == 1'b0, "R10 enable low", miso_oe_o, 0);
        end
        wait_n(6);
        chk(rx_byte_o == held, "R10 byte kept", rx_byte_o, held);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule